// File: doc/BRIEF.md
# Trigger Readout Sequencer with Supply-Settle Wait

This block runs the acquisition cycle of a switched-capacitor waveform sampler. While idle it keeps the sampling wave running and tracks the running cell position, one cell per clock. When a trigger is accepted it stops sampling and latches that position as the trigger cell. It then holds for a software-set number of clock cycles so the analog supply can recover from the load step. After that it converts every cell of the channel through an external ADC start/valid handshake and restarts sampling.

The settle count trades dead time against baseline error. A typical setting is about 120 µs worth of clock cycles, and zero removes the wait. Conversions begin at the trigger cell and walk upward through the ring, wrapping to cell 0, so samples come out in time order. Triggers that arrive while the block is busy are counted and otherwise ignored. If the ADC never answers, a watchdog flags the error and returns the block to sampling.

States: SAMPLE (idle, wave running), START (readout-start, one cycle), SETTLE (supply wait), READ_REQ (conversion request), READ_WAIT (waiting for the ADC), REARM (sampling restarted, still busy). Transitions:
- SAMPLE→START on an accepted trigger.
- START→READ_REQ when the latched count is zero, otherwise START→SETTLE.
- SETTLE→READ_REQ when the wait expires.
- READ_REQ→READ_WAIT always.
- READ_WAIT→READ_REQ on a valid strobe for a cell that is not the last.
- READ_WAIT→REARM on the valid strobe for the last cell.
- READ_WAIT→SAMPLE on timeout.
- REARM→SAMPLE always.

Top module: `trig_readout_seq`

## Requirements
- R1: After reset, sample_en is 1 and busy, adc_start, sample_valid, err_timeout and rej_count are all 0.
- R2: While sample_en is high, the running cell position advances by one per clock, from CELLS-1 back to 0, starting at 0 after reset. It holds while sampling is stopped. An accepted trigger copies the position held before that clock edge into trig_cell, which then stays unchanged until the next accepted trigger.
- R3: A trigger is accepted only when busy is low. In the cycle after acceptance, busy is 1, sample_en is 0 and adc_start is 0. This is the readout-start cycle.
- R4: With a latched settle count N, the first adc_start is high exactly N+2 cycles after the accepting edge's cycle: one readout-start cycle, then N settle cycles. N = 0 goes straight from readout-start to the first conversion.
- R5: settle_cfg is sampled only at trigger acceptance. Changing it during a wait does not alter that wait.
- R6: One event performs exactly CELLS conversions. cell_addr starts at trig_cell and rises by one per conversion, wrapping from CELLS-1 to 0. adc_start is a one-cycle pulse, and the next one follows only after adc_valid.
- R7: Each adc_valid accepted while waiting gives sample_valid one cycle later, with sample_data equal to adc_data and sample_cell equal to the converted address. sample_last is 1 only for the final cell.
- R8: In the cycle where the last sample is presented, sample_en is already 1 and busy is still 1. busy falls in the following cycle.
- R9: A trigger while busy is high changes no readout behaviour. It increments rej_count by one, and rej_count saturates at all ones.
- R10: If adc_valid does not arrive within TIMEOUT cycles of waiting, err_timeout is set, busy falls and sample_en rises on the next cycle, and no further samples are produced. err_timeout clears when the next trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger request, sampled every cycle |
| settle_cfg | input | SETTLE_W | Supply-settle wait length in clock cycles |
| adc_start | output | 1 | One-cycle conversion request |
| adc_valid | input | 1 | Conversion result strobe |
| adc_data | input | DATA_W | Conversion result |
| cell_addr | output | CELL_W | Cell selected for conversion |
| sample_valid | output | 1 | Sample output strobe |
| sample_data | output | DATA_W | Converted value |
| sample_cell | output | CELL_W | Cell the sample came from |
| sample_last | output | 1 | Marks the final sample of an event |
| trig_cell | output | CELL_W | Cell position where sampling stopped |
| busy | output | 1 | Dead-time flag, high from acceptance until re-arm completes |
| sample_en | output | 1 | Sampling wave running |
| err_timeout | output | 1 | ADC handshake timed out |
| rej_count | output | REJ_W | Saturating count of triggers ignored while busy |

## Verification
The bench measures the distance from trigger to first conversion for a nonzero wait, a zero wait and a wait whose setting is rewritten mid-wait. A design that skips the readout-start cycle, reloads the setting late or counts off by one would move that first conversion by a cycle or more. It triggers at cell positions that force the read address to wrap, so a design that starts at cell 0 or fails to wrap would give a wrong address order. It fires triggers during readout, so a design that accepts them would restart the event, and one that counts them wrongly would miss saturation. It also silences the ADC: a design without the watchdog would hang busy, and one that goes through re-arm would drop busy a cycle late.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_START,
        ST_SETTLE,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_REARM
    } trs_state_t;

endpackage

// File: rtl/trs_settle_timer.sv
module trs_settle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == W'(1));

endmodule

// File: rtl/trs_cell_ptr.sv
module trs_cell_ptr #(
    parameter int CELLS  = 1024,
    parameter int CELL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              capture,
    input  logic              step,
    output logic [CELL_W-1:0] trig_cell,
    output logic [CELL_W-1:0] rd_addr,
    output logic              rd_last
);

    localparam logic [CELL_W-1:0] TOP = CELL_W'(CELLS - 1);

    logic [CELL_W-1:0] pos_q;
    logic [CELL_W-1:0] rd_cnt_q;

    function automatic logic [CELL_W-1:0] ring_next(input logic [CELL_W-1:0] v);
        return (v == TOP) ? '0 : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (run) begin
            pos_q <= ring_next(pos_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_cell <= '0;
            rd_addr   <= '0;
            rd_cnt_q  <= '0;
        end else if (capture) begin
            trig_cell <= pos_q;
            rd_addr   <= pos_q;
            rd_cnt_q  <= '0;
        end else if (step) begin
            rd_addr   <= ring_next(rd_addr);
            rd_cnt_q  <= rd_cnt_q + 1'b1;
        end
    end

    assign rd_last = (rd_cnt_q == TOP);

endmodule

// File: rtl/trs_adc_watch.sv
module trs_adc_watch #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count,
    output logic expired
);

    localparam int WW = $clog2(TIMEOUT + 1);
    localparam logic [WW-1:0] LIMIT = WW'(TIMEOUT - 1);

    logic [WW-1:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wd_q <= '0;
        end else if (count && wd_q != LIMIT) begin
            wd_q <= wd_q + 1'b1;
        end
    end

    assign expired = (wd_q == LIMIT);

endmodule

// File: rtl/trig_readout_seq.sv
module trig_readout_seq #(
    parameter int CELLS    = 1024,
    parameter int DATA_W   = 12,
    parameter int SETTLE_W = 16,
    parameter int TIMEOUT  = 256,
    parameter int REJ_W    = 16,
    localparam int CELL_W  = $clog2(CELLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_in,
    input  logic [SETTLE_W-1:0] settle_cfg,
    output logic                adc_start,
    input  logic                adc_valid,
    input  logic [DATA_W-1:0]   adc_data,
    output logic [CELL_W-1:0]   cell_addr,
    output logic                sample_valid,
    output logic [DATA_W-1:0]   sample_data,
    output logic [CELL_W-1:0]   sample_cell,
    output logic                sample_last,
    output logic [CELL_W-1:0]   trig_cell,
    output logic                busy,
    output logic                sample_en,
    output logic                err_timeout,
    output logic [REJ_W-1:0]    rej_count
);

    import trs_pkg::*;

    trs_state_t state_q, state_d;

    logic accept, step, settle_zero, settle_one, wd_expired, rd_last, timeout_hit;
    logic [CELL_W-1:0] rd_addr;

    assign accept      = (state_q == ST_SAMPLE) && trig_in;
    assign step        = (state_q == ST_READ_WAIT) && adc_valid;
    assign timeout_hit = (state_q == ST_READ_WAIT) && !adc_valid && wd_expired;

    trs_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (settle_cfg),
        .dec      (state_q == ST_SETTLE),
        .is_zero  (settle_zero),
        .is_one   (settle_one)
    );

    trs_cell_ptr #(.CELLS(CELLS), .CELL_W(CELL_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .run       (sample_en),
        .capture   (accept),
        .step      (step),
        .trig_cell (trig_cell),
        .rd_addr   (rd_addr),
        .rd_last   (rd_last)
    );

    trs_adc_watch #(.TIMEOUT(TIMEOUT)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q == ST_READ_REQ),
        .count   (state_q == ST_READ_WAIT),
        .expired (wd_expired)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE:    if (trig_in) state_d = ST_START;
            ST_START:     state_d = settle_zero ? ST_READ_REQ : ST_SETTLE;
            ST_SETTLE:    if (settle_one || settle_zero) state_d = ST_READ_REQ;
            ST_READ_REQ:  state_d = ST_READ_WAIT;
            ST_READ_WAIT: begin
                if (adc_valid)        state_d = rd_last ? ST_REARM : ST_READ_REQ;
                else if (wd_expired)  state_d = ST_SAMPLE;
            end
            ST_REARM:     state_d = ST_SAMPLE;
            default:      state_d = ST_SAMPLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SAMPLE;
        else     state_q <= state_d;
    end

    // state outputs
    always_comb begin
        sample_en = 1'b0;
        busy      = 1'b1;
        adc_start = 1'b0;
        unique case (state_q)
            ST_SAMPLE:   begin sample_en = 1'b1; busy = 1'b0; end
            ST_REARM:    sample_en = 1'b1;
            ST_READ_REQ: adc_start = 1'b1;
            default:     ;
        endcase
    end

    assign cell_addr = rd_addr;

    // sample stream, error flag, rejected-trigger tally
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_valid <= 1'b0;
            sample_data  <= '0;
            sample_cell  <= '0;
            sample_last  <= 1'b0;
            err_timeout  <= 1'b0;
            rej_count    <= '0;
        end else begin
            sample_valid <= step;
            if (step) begin
                sample_data <= adc_data;
                sample_cell <= rd_addr;
                sample_last <= rd_last;
            end
            if (accept)           err_timeout <= 1'b0;
            else if (timeout_hit) err_timeout <= 1'b1;
            if (busy && trig_in && rej_count != {REJ_W{1'b1}})
                rej_count <= rej_count + 1'b1;
        end
    end

endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int CELL_W = 10,
    parameter int REJ_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_in,
    input logic              busy,
    input logic              sample_en,
    input logic              adc_start,
    input logic              adc_valid,
    input logic              sample_valid,
    input logic              sample_last,
    input logic [CELL_W-1:0] trig_cell,
    input logic              err_timeout,
    input logic [REJ_W-1:0]  rej_count
);

    assert_idle_runs_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sample_en);

    assert_trig_cell_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(trig_cell));

    assert_start_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!adc_start && !sample_en));

    assert_convert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (busy && !sample_en));

    assert_sample_after_valid_R7: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(adc_valid));

    assert_release_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && sample_last) |=> !busy);

    assert_reject_tally_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && trig_in && rej_count != {REJ_W{1'b1}})
            |=> rej_count == $past(rej_count) + 1'b1);

    assert_timeout_exit_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (!busy && $past(busy)));

endmodule

bind trig_readout_seq trs_checker #(.CELL_W(CELL_W), .REJ_W(REJ_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_in      (trig_in),
    .busy         (busy),
    .sample_en    (sample_en),
    .adc_start    (adc_start),
    .adc_valid    (adc_valid),
    .sample_valid (sample_valid),
    .sample_last  (sample_last),
    .trig_cell    (trig_cell),
    .err_timeout  (err_timeout),
    .rej_count    (rej_count)
);

// File: tb/sim_trig_readout_seq.sv
module sim_trig_readout_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 16;
    localparam int CW    = 4;
    localparam int TMO   = 6;
    localparam int RW    = 2;
    localparam int DW    = 12;
    localparam int SW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_in = 1'b0;
    logic [SW-1:0] settle_cfg = '0;
    logic          adc_start;
    logic          adc_valid = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic [CW-1:0] cell_addr;
    logic          sample_valid;
    logic [DW-1:0] sample_data;
    logic [CW-1:0] sample_cell;
    logic          sample_last;
    logic [CW-1:0] trig_cell;
    logic          busy, sample_en, err_timeout;
    logic [RW-1:0] rej_count;

    int checks = 0;
    int errors = 0;

    trig_readout_seq #(.CELLS(CELLS), .DATA_W(DW), .SETTLE_W(SW),
                       .TIMEOUT(TMO), .REJ_W(RW)) u0 (
        .clk(clk), .rst(rst), .trig_in(trig_in), .settle_cfg(settle_cfg),
        .adc_start(adc_start), .adc_valid(adc_valid), .adc_data(adc_data),
        .cell_addr(cell_addr), .sample_valid(sample_valid), .sample_data(sample_data),
        .sample_cell(sample_cell), .sample_last(sample_last), .trig_cell(trig_cell),
        .busy(busy), .sample_en(sample_en), .err_timeout(err_timeout),
        .rej_count(rej_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected running cell position, per R2
    int  pos_m = 0;
    bit  pos_inc = 1'b0;
    always @(negedge clk) begin
        pos_inc <= sample_en;
        if (rst)          pos_m <= 0;
        else if (pos_inc) pos_m <= (pos_m + 1) % CELLS;
    end

    // ADC model
    int adc_lat = 1;
    bit adc_mute = 1'b0;
    int salt = 0;
    bit pend = 1'b0;
    int pcnt = 0;
    int paddr = 0;

    function automatic logic [DW-1:0] code(input int addr, input int s);
        return DW'(addr * 37 + s);
    endfunction

    always @(negedge clk) begin
        adc_valid = 1'b0;
        if (pend && pcnt == 0) begin
            adc_valid = 1'b1;
            adc_data  = code(paddr, salt);
            pend      = 1'b0;
        end else if (pend) begin
            pcnt = pcnt - 1;
        end
        if (adc_start && !adc_mute) begin
            pend  = 1'b1;
            pcnt  = adc_lat - 1;
            paddr = int'(cell_addr);
        end
    end

    // sample collector
    int n = 0;
    int gc [CELLS];
    int gd [CELLS];
    bit gl [CELLS];
    always @(negedge clk) begin
        if (sample_valid) begin
            if (n < CELLS) begin
                gc[n] = int'(sample_cell);
                gd[n] = int'(sample_data);
                gl[n] = sample_last;
            end
            n = n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        chk("R1", "sample_en after reset", int'(sample_en), 1);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "adc_start after reset", int'(adc_start), 0);
        chk("R1", "sample_valid after reset", int'(sample_valid), 0);
        chk("R1", "err_timeout after reset", int'(err_timeout), 0);
        chk("R1", "rej_count after reset", int'(rej_count), 0);
    endtask

    // one full event; late_cfg >= 0 rewrites settle_cfg during the wait (R5);
    // noise > 0 fires that many triggers while busy (R9)
    task automatic t_event(input int settle, input int lat, input int late_cfg, input int noise);
        int tc, k, guard, pulses, bad_addr, bad_data, bad_last, rej0, exp_rej;
        adc_lat    = lat;
        settle_cfg = SW'(settle);
        salt       = salt + 11;
        @(negedge clk); #1;
        tc = pos_m;
        n = 0;
        trig_in = 1'b1;
        @(negedge clk); #1;
        trig_in = 1'b0;
        chk("R3", "busy in readout-start", int'(busy), 1);
        chk("R3", "sample_en in readout-start", int'(sample_en), 0);
        chk("R3", "adc_start in readout-start", int'(adc_start), 0);
        chk("R2", "trig_cell captured", int'(trig_cell), tc);
        chk("R10", "err_timeout cleared on accept", int'(err_timeout), 0);
        if (late_cfg >= 0) settle_cfg = SW'(late_cfg);
        k = 1;
        while (!adc_start && k < 1000) begin
            @(negedge clk); #1;
            k++;
        end
        if (late_cfg >= 0) chk("R5", "wait unchanged by late write", k, settle + 2);
        else               chk("R4", "trigger to first conversion", k, settle + 2);
        rej0 = int'(rej_count);
        guard = 0;
        pulses = 0;
        while (!(sample_valid && sample_last) && guard < 2000) begin
            if (pulses < 2 * noise) begin
                trig_in = (pulses % 2 == 0);
                pulses++;
            end else begin
                trig_in = 1'b0;
            end
            @(negedge clk); #1;
            guard++;
        end
        trig_in = 1'b0;
        chk("R8", "sample_en with last sample", int'(sample_en), 1);
        chk("R8", "busy with last sample", int'(busy), 1);
        @(negedge clk); #1;
        chk("R8", "busy after last sample", int'(busy), 0);
        chk("R6", "conversions per event", n, CELLS);
        bad_addr = 0; bad_data = 0; bad_last = 0;
        for (int i = 0; i < CELLS; i++) begin
            if (gc[i] != (tc + i) % CELLS) bad_addr++;
            if (gd[i] != int'(code((tc + i) % CELLS, salt))) bad_data++;
            if (gl[i] != (i == CELLS - 1)) bad_last++;
        end
        chk("R6", "cell order from trigger cell with wrap", bad_addr, 0);
        chk("R7", "sample data matches conversion", bad_data, 0);
        chk("R7", "sample_last placement", bad_last, 0);
        if (noise > 0) begin
            exp_rej = rej0 + noise;
            if (exp_rej > (1 << RW) - 1) exp_rej = (1 << RW) - 1;
            chk("R9", "rejected tally saturating", int'(rej_count), exp_rej);
            chk("R9", "trig_cell kept on rejected triggers", int'(trig_cell), tc);
        end
    endtask

    task automatic t_timeout();
        int k, j;
        adc_mute   = 1'b1;
        settle_cfg = '0;
        n = 0;
        @(negedge clk); #1;
        trig_in = 1'b1;
        @(negedge clk); #1;
        trig_in = 1'b0;
        k = 1;
        while (!adc_start && k < 1000) begin
            @(negedge clk); #1;
            k++;
        end
        chk("R4", "zero wait to first conversion", k, 2);
        j = 0;
        while (busy && j < 100) begin
            @(negedge clk); #1;
            j++;
        end
        chk("R10", "cycles from request to idle", j, TMO + 1);
        chk("R10", "err_timeout set", int'(err_timeout), 1);
        chk("R10", "sample_en after timeout", int'(sample_en), 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "no samples after timeout", n, 0);
        adc_mute = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        t_event(5, 1, -1, 0);   // R2 R3 R4 R6 R7 R8
        repeat (7) @(negedge clk);
        t_event(0, 3, -1, 0);   // R4 zero wait, wrap
        t_event(6, 2, 40, 5);   // R5 late write, R9 rejected triggers
        t_timeout();            // R10
        repeat (2) @(negedge clk);
        t_event(2, 1, -1, 0);   // R10 error clears
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule